// File: doc/BRIEF.md
# Z80 Banked Memory Mapper

This block sits between a Z80 CPU bus and a single 512K x8 static RAM. It turns the CPU's 64K address space into a window onto 16 physical banks of 32K each. CPU addresses with A15 low fall in a lower window whose physical bank comes from a software-written select register. CPU addresses with A15 high always reach the top physical bank, bank 15, which holds code and data shared by every bank. The block decodes the bus strobes and drives the RAM's 19 address lines and its active-low chip, output and write enables.

Software changes the lower window with an OUT to one fixed I/O port and reads the register back with an IN from the same port. Reset selects bank 0, so the power-on monitor runs from it. Other banks can then be switched in, for example one for the operating system and the rest as a RAM disk. The strobe decode is combinational. The select register is clocked by the CPU clock and changes only on an I/O write, so a new bank applies from the next memory cycle onward. Every bus pin here is a plain control or address line: the Z80 bus has no back-pressure, so there is no valid/ready interface.

Top module: `zbank_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the select register holds 0x00. A lower-window access (A15=0) then drives RAM address bits 18:15 to 0.
- R2: A memory access with CPU A15=1 drives RAM address bits 18:15 to 4'b1111, whatever the select register holds.
- R3: A memory access with CPU A15=0 drives RAM address bits 18:15 from select register bits 3:0. In every memory access, RAM address bits 14:0 equal CPU address bits 14:0.
- R4: RAM chip enable (active low) is low exactly when MREQ is low and IORQ is high.
- R5: RAM output enable is low exactly when the chip is enabled and RD is low. RAM write enable is low exactly when the chip is enabled and WR is low.
- R6: During an I/O cycle (IORQ low, M1 high) or an interrupt acknowledge (IORQ low, M1 low), all three RAM enables stay high.
- R7: An I/O write (IORQ low, WR low, M1 high) whose address bits 7:0 equal the port number (default 0x1F) loads the data byte into the select register at the next rising clock edge. Data bits 3:0 form the bank number. The new bank applies only to memory cycles that follow.
- R8: I/O writes to any other port number, and any I/O cycle with M1 low, leave the select register unchanged.
- R9: An I/O read (IORQ low, RD low, M1 high) of the port number drives the full select register byte on the data output and raises the data-output enable. In all other cycles the data-output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data_in | input | 8 | CPU data bus, written by the CPU |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / interrupt-acknowledge marker, active low |
| ram_addr | output | 19 | Physical RAM address |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| cpu_data_out | output | 8 | Read-back value for the CPU data bus |
| cpu_data_oe | output | 1 | High while the block drives the CPU data bus |

## Verification
The hardest case to reach from the ports is an I/O cycle that looks like a bank write but must be ignored. Examples are a write with M1 low, as in an interrupt acknowledge, and a write to a port that differs from the select port in one bit. These leave no mark on the outputs during the cycle itself. The stimulus therefore follows each such cycle with a lower-window memory access and an IN from the select port, and compares both with the bank the bench model expects. Random cycles mix these near-miss writes with real ones, and directed cycles check that the common upper half never follows the select register.

// File: rtl/zbank_pkg.sv
package zbank_pkg;

  // Snapshot of the Z80 control strobes, all active low.
  typedef struct packed {
    logic mreq_n;
    logic iorq_n;
    logic rd_n;
    logic wr_n;
    logic m1_n;
  } zb_bus_t;

  // Decoded cycle kinds produced by the strobe decoder.
  typedef struct packed {
    logic mem_cyc;
    logic mem_rd;
    logic mem_wr;
    logic io_wr_hit;
    logic io_rd_hit;
  } zb_cyc_t;

endpackage

// File: rtl/zbank_decode.sv
module zbank_decode
  import zbank_pkg::*;
#(
  parameter int IO_AW = 8,
  parameter logic [IO_AW-1:0] SEL_PORT = 8'h1F
) (
  input  zb_bus_t          bus,
  input  logic [IO_AW-1:0] io_addr,
  output zb_cyc_t          cyc
);

  logic port_match;
  logic io_plain;

  always_comb begin
    port_match = (io_addr == SEL_PORT);
    // An I/O cycle with M1 high is a real port access. With M1 low it is
    // an interrupt acknowledge and must not reach the select register.
    io_plain   = !bus.iorq_n && bus.m1_n;

    cyc.mem_cyc   = !bus.mreq_n && bus.iorq_n;
    cyc.mem_rd    = cyc.mem_cyc && !bus.rd_n;
    cyc.mem_wr    = cyc.mem_cyc && !bus.wr_n;
    cyc.io_wr_hit = io_plain && !bus.wr_n && port_match;
    cyc.io_rd_hit = io_plain && !bus.rd_n && port_match;
  end

endmodule

// File: rtl/zbank_sel_reg.sv
module zbank_sel_reg #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_hit,
  output logic [DATA_W-1:0] sel_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= RST_VAL;
    end else if (load) begin
      sel_q <= wdata;
    end
  end

  always_comb begin
    rdata_oe = rd_hit;
    rdata    = rd_hit ? sel_q : '0;
  end

endmodule

// File: rtl/zbank_addr_map.sv
module zbank_addr_map #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 4,
  localparam int LOW_W = ADDR_W - 1,
  localparam int RAM_W = LOW_W + BANK_W
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BANK_W-1:0] win_bank,
  output logic [RAM_W-1:0]  ram_addr
);

  localparam logic [BANK_W-1:0] COMMON_BANK = '1;

  logic [BANK_W-1:0] phys_bank;

  always_comb begin
    phys_bank = cpu_addr[ADDR_W-1] ? COMMON_BANK : win_bank;
    ram_addr  = {phys_bank, cpu_addr[LOW_W-1:0]};
  end

endmodule

// File: rtl/zbank_ctrl.sv
module zbank_ctrl
  import zbank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 4,
  parameter int IO_AW  = 8,
  parameter logic [IO_AW-1:0] SEL_PORT = 8'h1F,
  localparam int RAM_W = ADDR_W - 1 + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data_in,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  output logic [RAM_W-1:0]  ram_addr,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] cpu_data_out,
  output logic              cpu_data_oe
);

  zb_bus_t           bus;
  zb_cyc_t           cyc;
  logic [DATA_W-1:0] sel_q;

  always_comb begin
    bus.mreq_n = mreq_n;
    bus.iorq_n = iorq_n;
    bus.rd_n   = rd_n;
    bus.wr_n   = wr_n;
    bus.m1_n   = m1_n;
  end

  zbank_decode #(
    .IO_AW   (IO_AW),
    .SEL_PORT(SEL_PORT)
  ) dec_i (
    .bus    (bus),
    .io_addr(cpu_addr[IO_AW-1:0]),
    .cyc    (cyc)
  );

  zbank_sel_reg #(
    .DATA_W (DATA_W),
    .RST_VAL('0)
  ) sel_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cyc.io_wr_hit),
    .wdata   (cpu_data_in),
    .rd_hit  (cyc.io_rd_hit),
    .sel_q   (sel_q),
    .rdata   (cpu_data_out),
    .rdata_oe(cpu_data_oe)
  );

  zbank_addr_map #(
    .ADDR_W(ADDR_W),
    .BANK_W(BANK_W)
  ) map_i (
    .cpu_addr(cpu_addr),
    .win_bank(sel_q[BANK_W-1:0]),
    .ram_addr(ram_addr)
  );

  always_comb begin
    ram_ce_n = !cyc.mem_cyc;
    ram_oe_n = !cyc.mem_rd;
    ram_we_n = !cyc.mem_wr;
  end

endmodule

// File: rtl/zbank_ctrl_chk.sv
module zbank_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 4,
  parameter int IO_AW  = 8,
  parameter logic [IO_AW-1:0] SEL_PORT = 8'h1F,
  localparam int RAM_W = ADDR_W - 1 + BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_data_in,
  input logic              mreq_n,
  input logic              iorq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              m1_n,
  input logic [RAM_W-1:0]  ram_addr,
  input logic              ram_ce_n,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic [DATA_W-1:0] cpu_data_out,
  input logic              cpu_data_oe,
  input logic [DATA_W-1:0] sel_q
);

  logic port_wr;
  assign port_wr = !iorq_n && m1_n && !wr_n && (cpu_addr[IO_AW-1:0] == SEL_PORT);

  assert_common_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce_n && cpu_addr[ADDR_W-1]) |-> (ram_addr[RAM_W-1 -: BANK_W] == '1));

  assert_io_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !iorq_n |-> (ram_ce_n && ram_oe_n && ram_we_n));

  assert_we_needs_mreq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!mreq_n && !wr_n && !ram_ce_n));

  assert_oe_needs_mreq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> (!mreq_n && !rd_n && !ram_ce_n));

  assert_write_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> (sel_q == $past(cpu_data_in)));

  assert_hold_otherwise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr |=> $stable(sel_q));

  assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_data_oe |-> (!iorq_n && !rd_n && cpu_data_out == sel_q));

endmodule

bind zbank_ctrl zbank_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .BANK_W  (BANK_W),
  .IO_AW   (IO_AW),
  .SEL_PORT(SEL_PORT)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .cpu_data_in (cpu_data_in),
  .mreq_n      (mreq_n),
  .iorq_n      (iorq_n),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .m1_n        (m1_n),
  .ram_addr    (ram_addr),
  .ram_ce_n    (ram_ce_n),
  .ram_oe_n    (ram_oe_n),
  .ram_we_n    (ram_we_n),
  .cpu_data_out(cpu_data_out),
  .cpu_data_oe (cpu_data_oe),
  .sel_q       (sel_q)
);

// File: tb/zbank_ctrl_tb_top.sv
module zbank_ctrl_tb_top;

  localparam logic [7:0] PORT = 8'h1F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data_in = '0;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic [18:0] ram_addr;
  logic        ram_ce_n, ram_oe_n, ram_we_n;
  logic [7:0]  cpu_data_out;
  logic        cpu_data_oe;

  int total = 0;
  int bad = 0;
  logic [7:0] model_sel = 8'h00;

  always #5 clk = ~clk;

  zbank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data_in(cpu_data_in),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
    .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .cpu_data_out(cpu_data_out), .cpu_data_oe(cpu_data_oe)
  );

  function automatic logic [18:0] exp_addr(input logic [15:0] a, input logic [7:0] sel);
    return {(a[15] ? 4'hF : sel[3:0]), a[14:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    mreq_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1; m1_n = 1;
    #1;
    check(ram_ce_n && ram_oe_n && ram_we_n, "R4 idle enables", {ram_ce_n, ram_oe_n, ram_we_n}, 3'b111);
    check(!cpu_data_oe, "R9 idle data_oe", cpu_data_oe, 0);
  endtask

  task automatic mem_cycle(input logic [15:0] a, input bit is_wr);
    @(negedge clk);
    cpu_addr = a; mreq_n = 0; iorq_n = 1; m1_n = 1;
    rd_n = is_wr; wr_n = !is_wr;
    #1;
    check(ram_addr == exp_addr(a, model_sel), a[15] ? "R2 common bank addr" : "R3 window addr",
          ram_addr, exp_addr(a, model_sel));
    check(ram_ce_n == 0, "R4 ce in memory cycle", ram_ce_n, 0);
    check(ram_oe_n == is_wr && ram_we_n == !is_wr, "R5 oe/we",
          {ram_oe_n, ram_we_n}, {is_wr, !is_wr});
    idle();
  endtask

  task automatic io_write(input logic [7:0] port, input logic [7:0] d, input bit m1);
    @(negedge clk);
    cpu_addr = {8'hA5, port}; cpu_data_in = d; iorq_n = 0; mreq_n = 1;
    wr_n = 0; rd_n = 1; m1_n = m1;
    #1;
    check(ram_ce_n && ram_oe_n && ram_we_n, "R6 no strobe in io write",
          {ram_ce_n, ram_oe_n, ram_we_n}, 3'b111);
    if (port == PORT && m1) model_sel = d;
    idle();
  endtask

  task automatic io_read(input logic [7:0] port, input bit m1);
    @(negedge clk);
    cpu_addr = {8'h3C, port}; iorq_n = 0; mreq_n = 1; rd_n = 0; wr_n = 1; m1_n = m1;
    #1;
    check(ram_ce_n && ram_oe_n && ram_we_n, "R6 no strobe in io read",
          {ram_ce_n, ram_oe_n, ram_we_n}, 3'b111);
    if (port == PORT && m1)
      check(cpu_data_oe && cpu_data_out == model_sel, "R9 readback",
            {cpu_data_oe, cpu_data_out}, {1'b1, model_sel});
    else
      check(!cpu_data_oe, "R9 no drive on other cycle", cpu_data_oe, 0);
    idle();
  endtask

  initial begin : watchdog
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: value held during reset
    cpu_addr = 16'h1234; mreq_n = 0; rd_n = 0;
    #1;
    check(ram_addr[18:15] == 4'h0, "R1 bank during reset", ram_addr[18:15], 0);
    mreq_n = 1; rd_n = 1;
    @(negedge clk); rst_n = 1;
    mem_cycle(16'h0000, 0);
    mem_cycle(16'h7FFF, 1);
    io_read(PORT, 1);
    // R2 with bank 0 and later nonzero
    mem_cycle(16'h8000, 0);
    mem_cycle(16'hFFFF, 1);
    // R7 directed
    io_write(PORT, 8'h37, 1);
    mem_cycle(16'h4321, 0);
    mem_cycle(16'hC001, 0);
    io_read(PORT, 1);
    // R8 near misses: M1 low (interrupt acknowledge) and one-bit-off port
    io_write(PORT, 8'h0A, 0);
    mem_cycle(16'h0100, 0);
    io_read(PORT, 1);
    io_write(PORT ^ 8'h01, 8'h0C, 1);
    io_write(PORT ^ 8'h80, 8'h0D, 1);
    mem_cycle(16'h2222, 1);
    io_read(PORT, 1);
    io_read(PORT, 0);
    io_read(PORT ^ 8'h10, 1);
    // R6 interrupt acknowledge with MREQ high
    @(negedge clk);
    iorq_n = 0; m1_n = 0; #1;
    check(ram_ce_n && ram_oe_n && ram_we_n, "R6 int ack quiet",
          {ram_ce_n, ram_oe_n, ram_we_n}, 3'b111);
    idle();
    // bank 15 in window and back
    io_write(PORT, 8'hFF, 1);
    mem_cycle(16'h0ABC, 0);
    io_write(PORT, 8'h00, 1);
    mem_cycle(16'h0ABC, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] port;
      op = $urandom % 5;
      port = ($urandom % 3 == 0) ? (PORT ^ (8'h1 << ($urandom % 8))) : PORT;
      case (op)
        0: mem_cycle(16'($urandom), 0);
        1: mem_cycle(16'($urandom), 1);
        2: io_write(port, 8'($urandom), 1'($urandom % 4 != 0));
        3: io_read(port, 1'($urandom % 4 != 0));
        default: idle();
      endcase
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule